// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block turns one data-memory access per cycle into a 16-bit effective address. It holds eight 16-bit auxiliary registers and a 3-bit pointer that picks the current one. In direct mode the address is a 9-bit page number placed above a 7-bit offset from the instruction. That gives 512 pages of 128 words each.

In indirect mode the current register supplies the address. The register is then changed by a selectable post-modification. The choices include step by one and add or subtract register 0. There is also a reverse-carry form, in which the carry runs from the most significant bit toward the least. It walks buffers in bit-reversed order for FFT reordering. The same indirect access can also load a new pointer value, which takes effect for the next access.

A load port writes a register or the pointer. This is used for loads from memory and for immediate loads. A combinational read port returns any register for stores back to memory.

Top module: `aux_addr_gen`

## Requirements
- R1: After reset all eight registers read 0 and the pointer selects register 0.
- R2: A direct access (acc_valid_i=1, acc_indirect_i=0) outputs addr_o = {page_i, dir_offset_i}, with page_i in bits 15:7 and the offset in bits 6:0. It leaves every register unchanged.
- R3: An indirect access outputs, in the same cycle, the selected register's value before modification. The modified value is written to that register at the clock edge.
- R4: mod_sel_i code 0 leaves the register unchanged, code 1 adds one and code 2 subtracts one, all modulo 2^16.
- R5: Code 3 adds register 0 and code 4 subtracts register 0, using register 0's value before the edge.
- R6: Code 5 adds and code 6 subtracts register 0 with the carry or borrow running from bit 15 toward bit 0. Code 7 leaves the register unchanged.
- R7: When ptr_load_i is high on an indirect access, the pointer takes ptr_new_i after the edge. That access's address and modification still use the previously selected register.
- R8: When the pointer selects register 0, register 0 is modified like any other register; for example, code 3 doubles it.
- R9: When ld_en_i is high, ld_ptr_i=0 writes ld_data_i into register ld_sel_i, and ld_ptr_i=1 writes ld_data_i[2:0] into the pointer. A load-port write wins over a same-cycle indirect update of the same register or the pointer.
- R10: rd_data_o shows register rd_sel_i combinationally.
- R11: ptr_load_i has no effect on a direct access.
- R12: With acc_valid_i low, addr_o is 0 and no register or pointer changes, whatever the other access inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | An access happens this cycle |
| acc_indirect_i | input | 1 | 1 = indirect, 0 = direct |
| page_i | input | 9 | Page number for direct addressing |
| dir_offset_i | input | 7 | Offset within the page from the instruction |
| mod_sel_i | input | 3 | Post-modification code |
| ptr_load_i | input | 1 | Load the pointer on this indirect access |
| ptr_new_i | input | 3 | New pointer value |
| ld_en_i | input | 1 | Load-port write enable |
| ld_ptr_i | input | 1 | Load-port target: 1 = pointer, 0 = register |
| ld_sel_i | input | 3 | Register written by the load port |
| ld_data_i | input | 16 | Load-port data |
| rd_sel_i | input | 3 | Register shown on rd_data_o |
| rd_data_o | output | 16 | Read-port data for stores |
| addr_o | output | 16 | Effective address |

## Verification
Reverse-carry addition is run in a chain from zero with index 8. The addresses must come out 0, 8, 4, 12. This separates a carry that runs the wrong way from a plain adder. A reverse-carry subtraction follows, to catch a borrow handled like an add.

The step codes are driven across the 0xFFFF/0 boundary to expose wrong wrap-around. Pointer loads on indirect and direct accesses show whether the new pointer acts too early or is taken when it should be ignored.

Two collision cases are run. One has the load port hitting the register or the pointer that the access is updating. The other has register 0 as both the target and the index. Together they check the priority order and that register 0 is read before it is updated.

// File: rtl/aux_addr_pkg.sv
package aux_addr_pkg;

  localparam int MODW = 3;

  // Post-modification codes; values are fixed by the instruction field
  typedef enum logic [MODW-1:0] {
    MOD_KEEP  = 3'd0,
    MOD_INC   = 3'd1,
    MOD_DEC   = 3'd2,
    MOD_ADD0  = 3'd3,
    MOD_SUB0  = 3'd4,
    MOD_RADD0 = 3'd5,
    MOD_RSUB0 = 3'd6,
    MOD_RSV   = 3'd7
  } mod_e;

endpackage

// File: rtl/aux_modifier.sv
module aux_modifier
  import aux_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]   val_i,
  input  logic [AW-1:0]   idx_i,
  input  logic [MODW-1:0] mode_i,
  output logic [AW-1:0]   val_o
);

  logic [AW-1:0] val_r, idx_r, rsum_r, rdif_r, rsum, rdif;
  mod_e mode;

  assign mode = mod_e'(mode_i);

  // Mirror operands so an ordinary adder carries from the top bit downward
  for (genvar b = 0; b < AW; b++) begin : g_flip
    assign val_r[b] = val_i[AW-1-b];
    assign idx_r[b] = idx_i[AW-1-b];
    assign rsum[b]  = rsum_r[AW-1-b];
    assign rdif[b]  = rdif_r[AW-1-b];
  end

  assign rsum_r = val_r + idx_r;
  assign rdif_r = val_r - idx_r;

  always_comb begin
    unique case (mode)
      MOD_INC:   val_o = val_i + AW'(1);
      MOD_DEC:   val_o = val_i - AW'(1);
      MOD_ADD0:  val_o = val_i + idx_i;
      MOD_SUB0:  val_o = val_i - idx_i;
      MOD_RADD0: val_o = rsum;
      MOD_RSUB0: val_o = rdif;
      default:   val_o = val_i;
    endcase
  end

  // R5 R6: a zero index leaves the register unchanged in every indexed mode
  always_comb begin
    if (idx_i == '0 && (mode == MOD_ADD0 || mode == MOD_SUB0 ||
                        mode == MOD_RADD0 || mode == MOD_RSUB0)) begin
      zero_index_chk: assert (val_o == val_i)
        else $error("zero index changed the register");
    end
  end

endmodule

// File: rtl/aux_regfile.sv
module aux_regfile #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en_i,
  input  logic [SW-1:0]            upd_sel_i,
  input  logic [AW-1:0]            upd_val_i,
  input  logic                     wr_en_i,
  input  logic [SW-1:0]            wr_sel_i,
  input  logic [AW-1:0]            wr_val_i,
  output logic [NREG-1:0][AW-1:0]  regs_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [SW-1:0] IDX = SW'(g);
    logic          en_d;
    logic [AW-1:0] nxt_d;
    logic [AW-1:0] q;

    // The load port wins over an access update
    always_comb begin
      en_d  = 1'b0;
      nxt_d = q;
      if (wr_en_i && wr_sel_i == IDX) begin
        en_d  = 1'b1;
        nxt_d = wr_val_i;
      end else if (upd_en_i && upd_sel_i == IDX) begin
        en_d  = 1'b1;
        nxt_d = upd_val_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (en_d) q <= nxt_d;
    end

    assign regs_o[g] = q;
  end

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> regs_o[$past(wr_sel_i)] == $past(wr_val_i));

  // R2 R12
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en_i && !wr_en_i) |=> $stable(regs_o));

endmodule

// File: rtl/aux_ptr_reg.sv
module aux_ptr_reg #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_ld_i,
  input  logic [SW-1:0] acc_val_i,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_val_i,
  output logic [SW-1:0] ptr_o
);

  logic          en_d;
  logic [SW-1:0] nxt_d;

  always_comb begin
    en_d  = wr_en_i | acc_ld_i;
    nxt_d = wr_en_i ? wr_val_i : acc_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_o <= '0;
    else if (en_d) ptr_o <= nxt_d;
  end

  // R7
  ptr_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ld_i && !wr_en_i) |=> ptr_o == $past(acc_val_i));

endmodule

// File: rtl/aux_addr_gen.sv
module aux_addr_gen
  import aux_addr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int OFFW = 7,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG),
  localparam int PGW = AW - OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid_i,
  input  logic            acc_indirect_i,
  input  logic [PGW-1:0]  page_i,
  input  logic [OFFW-1:0] dir_offset_i,
  input  logic [MODW-1:0] mod_sel_i,
  input  logic            ptr_load_i,
  input  logic [SW-1:0]   ptr_new_i,
  input  logic            ld_en_i,
  input  logic            ld_ptr_i,
  input  logic [SW-1:0]   ld_sel_i,
  input  logic [AW-1:0]   ld_data_i,
  input  logic [SW-1:0]   rd_sel_i,
  output logic [AW-1:0]   rd_data_o,
  output logic [AW-1:0]   addr_o
);

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [SW-1:0]            ptr_q;
  logic [NREG-1:0][AW-1:0]  regs_w;
  logic [AW-1:0]            cur_val, mod_val;
  logic                     acc_ind, reg_we, ptr_we;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign acc_ind = acc_valid_i & acc_indirect_i;
  assign reg_we  = ld_en_i & ~ld_ptr_i;
  assign ptr_we  = ld_en_i & ld_ptr_i;
  assign cur_val = regs_w[ptr_q];

  aux_modifier #(.AW(AW)) mod_i (
    .val_i  (cur_val),
    .idx_i  (regs_w[0]),
    .mode_i (mod_sel_i),
    .val_o  (mod_val)
  );

  aux_regfile #(.AW(AW), .NREG(NREG)) rf_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .upd_en_i  (acc_ind),
    .upd_sel_i (ptr_q),
    .upd_val_i (mod_val),
    .wr_en_i   (reg_we),
    .wr_sel_i  (ld_sel_i),
    .wr_val_i  (ld_data_i),
    .regs_o    (regs_w)
  );

  aux_ptr_reg #(.SW(SW)) ptr_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_ld_i  (acc_ind & ptr_load_i),
    .acc_val_i (ptr_new_i),
    .wr_en_i   (ptr_we),
    .wr_val_i  (ld_data_i[SW-1:0]),
    .ptr_o     (ptr_q)
  );

  always_comb begin
    if (!acc_valid_i)   addr_o = '0;
    else if (acc_ind)   addr_o = cur_val;
    else                addr_o = {page_i, dir_offset_i};
  end

  assign rd_data_o = regs_w[rd_sel_i];

  // R4
  inc_writeback_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_ind && mod_sel_i == MOD_INC && !(reg_we && ld_sel_i == ptr_q))
      |=> regs_w[$past(ptr_q)] == $past(cur_val) + AW'(1));

  // R11
  direct_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid_i && !acc_indirect_i && !ptr_we) |=> $stable(ptr_q));

endmodule

// File: tb/aux_addr_gen_tb.sv
module aux_addr_gen_tb_top;

  localparam int CLK_PER = 10;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_ind, ptr_load, ld_en, ld_ptr;
  logic [8:0]  page;
  logic [6:0]  off;
  logic [2:0]  mods, ptr_new, ld_sel, rd_sel;
  logic [15:0] ld_data, rd_data, addr;

  int checks = 0;
  int errors = 0;
  item_t q[$];
  event smp;

  logic [15:0] m_ar [8];
  logic [2:0]  m_ptr;

  always #(CLK_PER/2) clk = ~clk;

  aux_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_indirect_i(acc_ind),
    .page_i(page), .dir_offset_i(off), .mod_sel_i(mods), .ptr_load_i(ptr_load),
    .ptr_new_i(ptr_new), .ld_en_i(ld_en), .ld_ptr_i(ld_ptr), .ld_sel_i(ld_sel),
    .ld_data_i(ld_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .addr_o(addr)
  );

  // Carry walks from bit 15 down to bit 0
  function automatic logic [15:0] rc_op(input logic [15:0] a, input logic [15:0] b, input bit sub);
    logic [15:0] bb = sub ? ~b : b;
    logic c = sub;
    logic [15:0] r;
    for (int i = 15; i >= 0; i--) begin
      r[i] = a[i] ^ bb[i] ^ c;
      c    = (a[i] & bb[i]) | (c & (a[i] ^ bb[i]));
    end
    return r;
  endfunction

  function automatic logic [15:0] model_mod(input logic [15:0] v, input logic [2:0] m);
    case (m)
      3'd1: return v + 16'd1;
      3'd2: return v - 16'd1;
      3'd3: return v + m_ar[0];
      3'd4: return v - m_ar[0];
      3'd5: return rc_op(v, m_ar[0], 1'b0);
      3'd6: return rc_op(v, m_ar[0], 1'b1);
      default: return v;
    endcase
  endfunction

  // Monitor: pops the expected address and compares it with the output
  always @(smp) begin
    item_t it;
    it = q.pop_front();
    checks++;
    if (addr !== it.exp) begin
      errors++;
      $display("FAIL %s: addr_o actual %h expected %h", it.tag, addr, it.exp);
    end
  end

  task automatic idle_inputs();
    acc_valid = 0; acc_ind = 0; ptr_load = 0; ld_en = 0; ld_ptr = 0;
    page = '0; off = '0; mods = '0; ptr_new = '0; ld_sel = '0; ld_data = '0;
  endtask

  // Driver: one cycle of access and/or load, expected address pushed to the queue
  task automatic cycle(input logic v, input logic ind, input logic [8:0] pg, input logic [6:0] of,
                       input logic [2:0] m, input logic pl, input logic [2:0] pn,
                       input logic we, input logic wp, input logic [2:0] ws,
                       input logic [15:0] wd, input string tag);
    item_t it;
    logic [15:0] nv;
    @(negedge clk);
    acc_valid = v; acc_ind = ind; page = pg; off = of; mods = m;
    ptr_load = pl; ptr_new = pn; ld_en = we; ld_ptr = wp; ld_sel = ws; ld_data = wd;
    it.exp = !v ? 16'h0 : (ind ? m_ar[m_ptr] : {pg, of});
    it.tag = tag;
    nv = model_mod(m_ar[m_ptr], m);
    q.push_back(it);
    #1 ->smp;
    @(posedge clk);
    if (v && ind) begin
      m_ar[m_ptr] = nv;
      if (pl) m_ptr = pn;
    end
    if (we) begin
      if (wp) m_ptr = wd[2:0];
      else    m_ar[ws] = wd;
    end
    #1 idle_inputs();
  endtask

  task automatic ind_acc(input logic [2:0] m, input string tag);
    cycle(1, 1, '0, '0, m, 0, '0, 0, 0, '0, '0, tag);
  endtask

  task automatic load(input logic wp, input logic [2:0] ws, input logic [15:0] wd, input string tag);
    cycle(0, 0, '0, '0, '0, 0, '0, 1, wp, ws, wd, tag);
  endtask

  task automatic chk_reg(input logic [2:0] s, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_sel = s;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d actual %h expected %h", tag, s, rd_data, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rd_sel = '0;
    for (int i = 0; i < 8; i++) m_ar[i] = '0;
    m_ptr = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 R10: reset state through the read port
    for (int i = 0; i < 8; i++) chk_reg(3'(i), 16'h0, "R1");
    // R2 R11: direct access with a pointer load request
    cycle(1, 0, 9'h1A5, 7'h33, 3'd1, 1, 3'd5, 0, 0, '0, '0, "R2");
    chk_reg(0, 16'h0, "R2");
    ind_acc(3'd0, "R11");            // pointer must still select register 0
    // R9: loads
    load(0, 0, 16'h0008, "R9");
    load(0, 2, 16'h1234, "R9");
    load(0, 3, 16'hFFFF, "R9");
    load(0, 7, 16'h0001, "R9");
    chk_reg(2, 16'h1234, "R9");
    load(1, 0, 16'h0001, "R9");      // pointer -> register 1
    // R6: reverse-carry add chain from 0 with index 8: 0,8,4,C
    ind_acc(3'd5, "R6");
    ind_acc(3'd5, "R6");
    ind_acc(3'd5, "R6");
    ind_acc(3'd5, "R6");
    chk_reg(1, 16'h0002, "R6");
    ind_acc(3'd6, "R6");
    chk_reg(1, 16'h000C, "R6");
    ind_acc(3'd7, "R6");
    chk_reg(1, 16'h000C, "R6");
    // R7 R3: pointer load applies after the access
    load(1, 0, 16'h0002, "R7");
    cycle(1, 1, '0, '0, 3'd1, 1, 3'd3, 0, 0, '0, '0, "R7");
    chk_reg(2, 16'h1235, "R7");
    // R4: wrap-around
    ind_acc(3'd1, "R4");             // FFFF -> 0
    chk_reg(3, 16'h0000, "R4");
    ind_acc(3'd2, "R4");             // 0 -> FFFF
    chk_reg(3, 16'hFFFF, "R4");
    ind_acc(3'd0, "R4");
    // R5
    ind_acc(3'd3, "R5");
    chk_reg(3, 16'h0007, "R5");
    ind_acc(3'd4, "R5");
    chk_reg(3, 16'hFFFF, "R5");
    // R8: register 0 as target and index
    cycle(1, 1, '0, '0, 3'd0, 1, 3'd0, 0, 0, '0, '0, "R8");
    ind_acc(3'd3, "R8");
    chk_reg(0, 16'h0010, "R8");
    // R9: load port wins over same-cycle update
    load(1, 0, 16'h0007, "R9");
    cycle(1, 1, '0, '0, 3'd1, 0, '0, 1, 0, 3'd7, 16'h5555, "R9");
    chk_reg(7, 16'h5555, "R9");
    cycle(1, 1, '0, '0, 3'd1, 1, 3'd2, 1, 1, '0, 16'h0001, "R9");
    ind_acc(3'd0, "R9");             // pointer must be 1
    // R12: no access
    cycle(0, 1, 9'h0FF, 7'h7F, 3'd1, 1, 3'd4, 0, 0, '0, '0, "R12");
    ind_acc(3'd0, "R12");
    for (int i = 0; i < 8; i++) chk_reg(3'(i), m_ar[i], "R12");

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule